// File: doc/BRIEF.md
# In-Lane 32-bit Element Permute Unit

This datapath block rearranges the 32-bit elements of a vector that is 128 or 256 bits wide. The vector is split into 128-bit lanes of four elements each. Every destination element takes a copy of one of the four source elements in its own lane, picked by a 2-bit select. Data is never moved from one lane to another.

The selects come from one of two places. In immediate mode, an 8-bit immediate holds four 2-bit fields, and the same four fields drive both lanes. In variable mode, a second vector holds one 32-bit control element per destination element. Only the two lowest bits of each control element are used. A narrow (128-bit) operation produces the low lane only and clears everything above it. Two encoding fields are checked for illegal combinations: a 4-bit register-specifier field and a W bit. When the encoding is illegal, the block raises an undefined-instruction flag and produces no result.

An operation is launched with a start strobe. The result, the valid strobe and the undefined flag are registered and appear one cycle later. Element data is handled as raw bit patterns and is never interpreted as floating point.

Top module: `lane_perm32`

## Requirements
- R1: A select value s (0 to 3) copies bits [32s+31:32s] of the element's own 128-bit lane to the destination element.
- R2: Destination elements 0 to 3 take data only from source bits [127:0]. Destination elements 4 to 7 take data only from source bits [255:128].
- R3: In immediate mode (imm_mode_i=1), destination element k of each lane is controlled by imm_i[2k+1:2k], for k = 0 to 3. The same fields are used in both lanes.
- R4: In variable mode (imm_mode_i=0), destination element i is controlled by ctl_i[32i+1:32i]. All other bits of ctl_i have no effect on the result.
- R5: When wide_i=0, res_o[255:128] is zero.
- R6: In immediate mode, a reg_spec_i value other than 4'b1111 makes the operation illegal. In variable mode, reg_spec_i has no effect.
- R7: When w_bit_i=1, the operation is illegal in both modes.
- R8: The cycle after a start, valid_o=1 and undef_o=0 if the operation is legal. If it is illegal, undef_o=1, valid_o=0 and res_o is all zeros. In any cycle that does not follow a start, valid_o and undef_o are 0.
- R9: Element bit patterns pass through unchanged, including NaN, denormal and negative-zero patterns.
- R10: After reset, res_o, valid_o and undef_o are zero. res_o keeps its value when no start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one operation |
| imm_mode_i | input | 1 | 1: selects come from imm_i; 0: selects come from ctl_i |
| wide_i | input | 1 | 1: 256-bit operation; 0: 128-bit operation |
| src_i | input | 256 | Source vector |
| ctl_i | input | 256 | Control vector, one control element per destination element |
| imm_i | input | 8 | Immediate holding four 2-bit select fields |
| reg_spec_i | input | 4 | Register-specifier field; must be all ones in immediate mode |
| w_bit_i | input | 1 | W bit; a value of 1 is illegal |
| res_o | output | 256 | Result vector |
| valid_o | output | 1 | High for one cycle when a legal result is ready |
| undef_o | output | 1 | High for one cycle when the encoding is illegal |

## Verification
The bench builds the block with its default parameters: 32-bit elements, four elements per lane and two lanes. These values give the full 256-bit vector and two lanes, so each test can see both the lane boundary and the zeroing of the upper half in narrow mode. With four selects per lane, identity, broadcast and reversal patterns can each be written as a single immediate. The same patterns can also be built as control vectors with random ignored bits, so both control paths are checked against each other.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
  localparam int ELEM_W    = 32;
  localparam int EPL       = 4;   // elements per 128-bit lane
  localparam int NUM_LANES = 2;
  localparam int SPEC_W    = 4;

  typedef enum logic {
    CTL_VAR = 1'b0,
    CTL_IMM = 1'b1
  } ctl_src_e;
endpackage

// File: rtl/lane_perm_decode.sv
module lane_perm_decode #(
  parameter int SPEC_W = 4
) (
  input  logic              imm_mode_i,
  input  logic [SPEC_W-1:0] reg_spec_i,
  input  logic              w_bit_i,
  output logic              illegal_o
);
  import lane_perm_pkg::*;

  ctl_src_e src_kind;
  logic     spec_bad;

  assign src_kind  = ctl_src_e'(imm_mode_i);
  // the specifier field is only reserved in immediate mode
  assign spec_bad  = (src_kind == CTL_IMM) && (reg_spec_i != {SPEC_W{1'b1}});
  assign illegal_o = w_bit_i || spec_bad;
endmodule

// File: rtl/lane_perm_ctrl.sv
module lane_perm_ctrl #(
  parameter int ELEM_W    = 32,
  parameter int EPL       = 4,
  parameter int NUM_LANES = 2,
  localparam int SEL_W    = $clog2(EPL),
  localparam int NUM_EL   = EPL * NUM_LANES,
  localparam int VEC_W    = ELEM_W * NUM_EL,
  localparam int IMM_W    = SEL_W * EPL
) (
  input  logic                    imm_mode_i,
  input  logic [VEC_W-1:0]        ctl_i,
  input  logic [IMM_W-1:0]        imm_i,
  output logic [NUM_EL*SEL_W-1:0] sel_o
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    localparam int K = e % EPL;  // position inside the lane
    logic [SEL_W-1:0] imm_sel, var_sel;
    assign imm_sel = imm_i[K*SEL_W +: SEL_W];
    assign var_sel = ctl_i[e*ELEM_W +: SEL_W];
    assign sel_o[e*SEL_W +: SEL_W] = imm_mode_i ? imm_sel : var_sel;
  end
endmodule

// File: rtl/lane_perm_lane.sv
module lane_perm_lane #(
  parameter int ELEM_W = 32,
  parameter int EPL    = 4,
  localparam int SEL_W  = $clog2(EPL),
  localparam int LANE_W = ELEM_W * EPL
) (
  input  logic [LANE_W-1:0]    src_i,
  input  logic [EPL*SEL_W-1:0] sel_i,
  input  logic                 en_i,
  output logic [LANE_W-1:0]    dst_o
);
  logic [EPL-1:0][ELEM_W-1:0] src_arr;
  assign src_arr = src_i;

  for (genvar k = 0; k < EPL; k++) begin : g_mux
    logic [SEL_W-1:0] sel;
    assign sel = sel_i[k*SEL_W +: SEL_W];
    always_comb begin
      dst_o[k*ELEM_W +: ELEM_W] = en_i ? src_arr[sel] : '0;
    end
  end
endmodule

// File: rtl/lane_perm32.sv
module lane_perm32 #(
  parameter int ELEM_W    = lane_perm_pkg::ELEM_W,
  parameter int EPL       = lane_perm_pkg::EPL,
  parameter int NUM_LANES = lane_perm_pkg::NUM_LANES,
  parameter int SPEC_W    = lane_perm_pkg::SPEC_W,
  localparam int SEL_W    = $clog2(EPL),
  localparam int NUM_EL   = EPL * NUM_LANES,
  localparam int LANE_W   = ELEM_W * EPL,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int IMM_W    = SEL_W * EPL,
  localparam int NARROW_LANES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              imm_mode_i,
  input  logic              wide_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [VEC_W-1:0]  ctl_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SPEC_W-1:0] reg_spec_i,
  input  logic              w_bit_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              valid_o,
  output logic              undef_o
);
  logic                    illegal;
  logic [NUM_EL*SEL_W-1:0] sel;
  logic [VEC_W-1:0]        perm;

  lane_perm_decode #(.SPEC_W(SPEC_W)) u_dec (
    .imm_mode_i (imm_mode_i),
    .reg_spec_i (reg_spec_i),
    .w_bit_i    (w_bit_i),
    .illegal_o  (illegal)
  );

  lane_perm_ctrl #(.ELEM_W(ELEM_W), .EPL(EPL), .NUM_LANES(NUM_LANES)) u_ctrl (
    .imm_mode_i (imm_mode_i),
    .ctl_i      (ctl_i),
    .imm_i      (imm_i),
    .sel_o      (sel)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic en;
    if (l < NARROW_LANES) begin : g_always
      assign en = 1'b1;
    end else begin : g_wide
      assign en = wide_i;
    end
    lane_perm_lane #(.ELEM_W(ELEM_W), .EPL(EPL)) u_lane (
      .src_i (src_i[l*LANE_W +: LANE_W]),
      .sel_i (sel[l*EPL*SEL_W +: EPL*SEL_W]),
      .en_i  (en),
      .dst_o (perm[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
      undef_o <= 1'b0;
    end else begin
      valid_o <= start_i && !illegal;
      undef_o <= start_i && illegal;
      if (start_i) res_o <= illegal ? '0 : perm;
    end
  end
endmodule

// File: rtl/lane_perm32_chk.sv
module lane_perm32_chk #(
  parameter int VEC_W  = 256,
  parameter int SPEC_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              imm_mode_i,
  input logic              wide_i,
  input logic [SPEC_W-1:0] reg_spec_i,
  input logic              w_bit_i,
  input logic [VEC_W-1:0]  res_o,
  input logic              valid_o,
  input logic              undef_o
);
  localparam int HALF = VEC_W / 2;

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && undef_o));

  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o && !undef_o);

  a_r8_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> res_o == '0);

  a_r7_w_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && w_bit_i |=> undef_o);

  a_r6_spec_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && imm_mode_i && reg_spec_i != {SPEC_W{1'b1}} |=> undef_o);

  a_r6_spec_var: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !imm_mode_i && !w_bit_i |=> valid_o);

  a_r5_narrow_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !wide_i |=> res_o[VEC_W-1:HALF] == '0);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(res_o));
endmodule

bind lane_perm32 lane_perm32_chk #(.VEC_W(VEC_W), .SPEC_W(SPEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .imm_mode_i (imm_mode_i),
  .wide_i     (wide_i),
  .reg_spec_i (reg_spec_i),
  .w_bit_i    (w_bit_i),
  .res_o      (res_o),
  .valid_o    (valid_o),
  .undef_o    (undef_o)
);

// File: tb/lane_perm32_tb.sv
module lane_perm32_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         imm_mode = 1'b0;
  logic         wide = 1'b0;
  logic [255:0] src = '0;
  logic [255:0] ctl = '0;
  logic [7:0]   imm = '0;
  logic [3:0]   spec = 4'hF;
  logic         wbit = 1'b0;
  logic [255:0] res;
  logic         valid, undef;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_perm32 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_mode_i(imm_mode),
    .wide_i(wide), .src_i(src), .ctl_i(ctl), .imm_i(imm),
    .reg_spec_i(spec), .w_bit_i(wbit), .res_o(res), .valid_o(valid),
    .undef_o(undef)
  );

  function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] c,
                                         input logic [7:0] im, input logic im_mode,
                                         input logic wd);
    logic [255:0] r = '0;
    for (int e = 0; e < 8; e++) begin
      int lane = e / 4;
      int k = e % 4;
      int sv = im_mode ? int'(im[2*k +: 2]) : int'(c[32*e +: 2]);
      if (wd || e < 4) r[32*e +: 32] = s[128*lane + 32*sv +: 32];
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // launch one op and sample outputs at the next falling edge
  task automatic run_op(input logic im_mode, input logic wd, input logic [255:0] s,
                        input logic [255:0] c, input logic [7:0] im,
                        input logic [3:0] sp, input logic wb);
    @(negedge clk);
    start = 1'b1; imm_mode = im_mode; wide = wd; src = s; ctl = c; imm = im;
    spec = sp; wbit = wb;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic legal_op(input string req, input logic im_mode, input logic wd,
                          input logic [255:0] s, input logic [255:0] c,
                          input logic [7:0] im);
    logic [255:0] exp = model(s, c, im, im_mode, wd);
    run_op(im_mode, wd, s, c, im, 4'hF, 1'b0);
    check(res == exp, req, res, exp);
    check(valid && !undef, {req, " valid"}, {254'd0, valid, undef}, 256'd2);
  endtask

  task automatic t_reset();
    check(res == '0 && !valid && !undef, "R10 reset", res, '0);
  endtask

  task automatic t_patterns();
    logic [255:0] s = rnd_vec();
    legal_op("R1 R3 identity", 1'b1, 1'b1, s, '0, 8'hE4);
    check(res == s, "R3 identity equals source", res, s);
    legal_op("R1 broadcast0", 1'b1, 1'b1, s, '0, 8'h00);
    legal_op("R1 broadcast1", 1'b1, 1'b1, s, '0, 8'h55);
    legal_op("R1 broadcast2", 1'b1, 1'b1, s, '0, 8'hAA);
    legal_op("R1 broadcast3", 1'b1, 1'b1, s, '0, 8'hFF);
    legal_op("R3 reversal", 1'b1, 1'b1, s, '0, 8'h1B);
  endtask

  task automatic t_lanes();
    logic [255:0] s;
    for (int i = 0; i < 8; i++) s[32*i +: 32] = 32'hA000_0000 + i;
    legal_op("R2 lane confine", 1'b1, 1'b1, s, '0, 8'h1B);
    check(res[159:128] == 32'hA000_0007 && res[31:0] == 32'hA000_0003,
          "R2 lane elements", res, s);
  endtask

  task automatic t_variable();
    logic [255:0] s = rnd_vec();
    logic [255:0] c = rnd_vec();
    logic [255:0] r1;
    legal_op("R4 variable", 1'b0, 1'b1, s, c, 8'h00);
    r1 = res;
    // flip every ignored control bit
    legal_op("R4 ignored bits", 1'b0, 1'b1, s, c ^ {8{32'hFFFF_FFFC}}, 8'h00);
    check(res == r1, "R4 ignored bits no effect", res, r1);
  endtask

  task automatic t_narrow();
    logic [255:0] s = rnd_vec();
    legal_op("R5 narrow imm", 1'b1, 1'b0, s, '0, 8'h93);
    check(res[255:128] == '0, "R5 upper zero imm", res, '0);
    legal_op("R5 narrow var", 1'b0, 1'b0, s, rnd_vec(), 8'h00);
    check(res[255:128] == '0, "R5 upper zero var", res, '0);
  endtask

  task automatic t_illegal();
    logic [255:0] s = rnd_vec();
    run_op(1'b1, 1'b1, s, '0, 8'hE4, 4'hE, 1'b0);
    check(undef && !valid && res == '0, "R6 bad spec imm", res, '0);
    run_op(1'b0, 1'b1, s, '0, 8'h00, 4'h0, 1'b0);
    check(valid && !undef && res == model(s, '0, 8'h00, 1'b0, 1'b1),
          "R6 spec ignored var", res, model(s, '0, 8'h00, 1'b0, 1'b1));
    run_op(1'b1, 1'b1, s, '0, 8'hE4, 4'hF, 1'b1);
    check(undef && !valid && res == '0, "R7 W imm", res, '0);
    run_op(1'b0, 1'b0, s, '0, 8'h00, 4'hF, 1'b1);
    check(undef && !valid && res == '0, "R7 W var", res, '0);
  endtask

  task automatic t_timing();
    logic [255:0] s = rnd_vec();
    logic [255:0] r1;
    legal_op("R8 latency", 1'b1, 1'b1, s, '0, 8'h4E);
    r1 = res;
    @(negedge clk);
    src = rnd_vec(); imm = 8'h1B;
    check(!valid && !undef, "R8 single pulse", {254'd0, valid, undef}, '0);
    @(negedge clk);
    check(res == r1, "R10 hold", res, r1);
  endtask

  task automatic t_special();
    logic [255:0] s = {32'h7FC0_0001, 32'h8000_0000, 32'h0000_0001, 32'hFF80_0000,
                       32'h7F80_0000, 32'h807F_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
    legal_op("R9 bit exact", 1'b1, 1'b1, s, '0, 8'hE4);
    check(res == s, "R9 patterns preserved", res, s);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic im_mode = 1'(i % 2);
      logic wd = 1'((i / 2) % 2);
      legal_op("R1 R2 R3 R4 random", im_mode, wd, rnd_vec(), rnd_vec(), 8'($urandom));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_patterns();
    t_lanes();
    t_variable();
    t_narrow();
    t_illegal();
    t_timing();
    t_special();
    t_random();
    finish_run();
  end
endmodule